// File: doc/BRIEF.md
# TDM Serial Port Status Flags

This block produces the four status flags of a synchronous, time-slotted serial port. On the receive side it captures the levels of two auxiliary control pins and turns them into input flags. It also records whether each received word began inside a frame-sync slot. On the transmit side it runs a time-slot counter and raises a flag while the current slot is the first slot of the frame.

Every event arrives as a one-cycle strobe that is synchronous to `clk_i`:

- a detected receive frame sync
- each received bit
- the move of a finished word into the receive data register
- a transmit slot boundary
- a transmit frame sync

Every flag is registered, so it changes one clock after the strobe that causes it. A synchronous clear input stands for the software reset, the port's own reset and the stop condition.

Top module: `tdm_status_flags`

## Requirements
- R1: The status word holds `status_o[0]` = input flag 0, `[1]` = input flag 1, `[2]` = transmit frame-sync flag and `[3]` = receive frame-sync flag. All four bits read 0 after `rst_ni` is low and in the cycle after `clr_i` is high.
- R2: Input flag 0 is forced to 0 one cycle after any cycle in which one of these holds: `sync_mode_i` is 0, `tx_en_i[1]` is 1, or `aux_out_i[0]` is 1.
- R3: Input flag 1 is forced to 0 one cycle after any cycle in which one of these holds: `sync_mode_i` is 0, `tx_en_i[2]` is 1, or `aux_out_i[1]` is 1.
- R4: After a receive frame sync, each auxiliary pin is sampled at the first `rx_bit_i` strobe. That strobe may come in the same cycle as the frame sync or later. Later bits of the frame are not sampled.
- R5: An enabled input flag takes the last sampled pin level only on an `rx_xfer_i` strobe. A new sample taken before that strobe leaves the visible flag unchanged.
- R6: In network mode (`net_mode_i`=1) with a transmitter enabled, the transmit frame-sync flag is 1 during slot 0 and 0 during every other slot. It is updated at each slot boundary or transmit frame sync.
- R7: The slot counter advances on `tx_slot_i` and wraps to slot 0 after slot `slots_i`, so a frame has `slots_i`+1 slots.
- R8: A `tx_fs_i` strobe forces the slot counter to slot 0, whatever slot it was in.
- R9: The transmit frame-sync flag reads 0 one cycle after any cycle in which `tx_en_i` is all zero.
- R10: In normal mode (`net_mode_i`=0) with a transmitter enabled, the transmit frame-sync flag reads 1 after any slot boundary or transmit frame sync.
- R11: On `rx_xfer_i`, the receive frame-sync flag becomes 1 when a frame sync arrived since the previous transfer, and 0 otherwise. A frame sync in the same cycle as a transfer counts toward the next word. The flag changes only on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear (soft reset, port reset, stop) |
| sync_mode_i | input | 1 | Synchronous mode select |
| net_mode_i | input | 1 | 1 = network (multi-slot) mode, 0 = normal mode |
| tx_en_i | input | 3 | Transmitter enables |
| aux_out_i | input | 2 | 1 = auxiliary pin configured as an output |
| aux_i | input | 2 | Auxiliary pin levels |
| rx_fs_i | input | 1 | Receive frame sync detected |
| rx_bit_i | input | 1 | Received bit strobe |
| rx_xfer_i | input | 1 | Word moved into the receive data register |
| tx_slot_i | input | 1 | Transmit slot boundary |
| tx_fs_i | input | 1 | Transmit frame sync |
| slots_i | input | 4 | Slots per frame minus one |
| status_o | output | 4 | {rfs, tfs, input flag 1, input flag 0} |

## Verification
The assertions assume that every event input is a one-cycle strobe sampled on `clk_i`, that the enables and the mode inputs may change in any cycle, and that `slots_i` is held steady while the counter runs. The stimulus changes mode and enable settings only between event strobes. It never puts a pin sample and a word transfer in the same cycle, so the rule for which value wins in that case is left untested. It keeps `slots_i` constant within each frame that it checks.

// File: rtl/tdm_flags_pkg.sv
package tdm_flags_pkg;
  localparam int ST_IF0 = 0;
  localparam int ST_IF1 = 1;
  localparam int ST_TFS = 2;
  localparam int ST_RFS = 3;
  localparam int ST_W   = 4;
endpackage

// File: rtl/aux_flag_chan.sv
module aux_flag_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic aux_i,
  input  logic rx_fs_i,
  input  logic rx_bit_i,
  input  logic rx_xfer_i,
  output logic flag_o
);
  logic pend_q, lat_q, flag_q;
  logic pend_d, take;

  assign pend_d = pend_q | rx_fs_i;
  assign take   = rx_bit_i & pend_d;

  // hidden capture latch, separate from the visible bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lat_q  <= 1'b0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      pend_q <= pend_d & ~take;
      if (take) lat_q <= aux_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (clr_i)     flag_q <= 1'b0;
    else if (!en_i)     flag_q <= 1'b0;
    else if (rx_xfer_i) flag_q <= lat_q;
  end

  assign flag_o = flag_q;

  // R2 for channel 0, R3 for channel 1
  p_flag_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o);
  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !rx_xfer_i && !clr_i |=> $stable(flag_o));
endmodule

// File: rtl/rx_fs_tag.sv
module rx_fs_tag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rx_fs_i,
  input  logic rx_xfer_i,
  output logic rfs_o
);
  logic word_fs_q, rfs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_fs_q <= 1'b0;
      rfs_q     <= 1'b0;
    end else if (clr_i) begin
      word_fs_q <= 1'b0;
      rfs_q     <= 1'b0;
    end else if (rx_xfer_i) begin
      rfs_q     <= word_fs_q;
      word_fs_q <= rx_fs_i;   // sync on the transfer cycle opens the next word
    end else begin
      word_fs_q <= word_fs_q | rx_fs_i;
    end
  end

  assign rfs_o = rfs_q;

  p_rfs_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_xfer_i && !clr_i |=> $stable(rfs_o));
endmodule

// File: rtl/tx_slot_tracker.sv
module tx_slot_tracker #(
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              net_mode_i,
  input  logic              tx_any_i,
  input  logic              tx_fs_i,
  input  logic              tx_slot_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic              tfs_o
);
  localparam logic [SLOT_W-1:0] SLOT0 = '0;

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              tfs_q, evt;

  assign evt = tx_fs_i | tx_slot_i;

  always_comb begin
    slot_d = slot_q;
    if (!net_mode_i || tx_fs_i)  slot_d = SLOT0;
    else if (tx_slot_i)          slot_d = (slot_q == slots_i) ? SLOT0 : slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT0;
      tfs_q  <= 1'b0;
    end else if (clr_i) begin
      slot_q <= SLOT0;
      tfs_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      if (!tx_any_i) tfs_q <= 1'b0;
      else if (evt)  tfs_q <= (slot_d == SLOT0);
    end
  end

  assign tfs_o = tfs_q;

  p_tfs_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_any_i |=> !tfs_o);
  p_fs_slot0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_mode_i && tx_any_i && tx_fs_i && !clr_i |=> tfs_o);
  p_normal_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !net_mode_i && tx_any_i && evt && !clr_i |=> tfs_o);
endmodule

// File: rtl/tdm_status_flags.sv
module tdm_status_flags
  import tdm_flags_pkg::*;
#(
  parameter int N_AUX  = 2,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sync_mode_i,
  input  logic              net_mode_i,
  input  logic [N_AUX:0]    tx_en_i,
  input  logic [N_AUX-1:0]  aux_out_i,
  input  logic [N_AUX-1:0]  aux_i,
  input  logic              rx_fs_i,
  input  logic              rx_bit_i,
  input  logic              rx_xfer_i,
  input  logic              tx_slot_i,
  input  logic              tx_fs_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic [ST_W-1:0]   status_o
);
  logic [N_AUX-1:0] if_en, if_flag;
  logic             tfs, rfs;

  for (genvar k = 0; k < N_AUX; k++) begin : g_aux
    // aux pin k pairs with transmitter k+1
    assign if_en[k] = sync_mode_i & ~tx_en_i[k+1] & ~aux_out_i[k];
    aux_flag_chan i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_i),
      .en_i      (if_en[k]),
      .aux_i     (aux_i[k]),
      .rx_fs_i   (rx_fs_i),
      .rx_bit_i  (rx_bit_i),
      .rx_xfer_i (rx_xfer_i),
      .flag_o    (if_flag[k])
    );
  end

  rx_fs_tag i_rfs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .rx_fs_i   (rx_fs_i),
    .rx_xfer_i (rx_xfer_i),
    .rfs_o     (rfs)
  );

  tx_slot_tracker #(.SLOT_W(SLOT_W)) i_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .net_mode_i (net_mode_i),
    .tx_any_i   (|tx_en_i),
    .tx_fs_i    (tx_fs_i),
    .tx_slot_i  (tx_slot_i),
    .slots_i    (slots_i),
    .tfs_o      (tfs)
  );

  always_comb begin
    status_o         = '0;
    status_o[ST_IF0] = if_flag[0];
    status_o[ST_IF1] = if_flag[1];
    status_o[ST_TFS] = tfs;
    status_o[ST_RFS] = rfs;
  end

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> status_o == '0);
endmodule

// File: tb/test_tdm_status_flags.sv
module test_tdm_status_flags;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0, clr = 1'b0;
  logic sync_p = 1'b0, net_p = 1'b0;
  logic [2:0] txen_p = '0;
  logic [1:0] dir_p = '0, aux_p = '0;
  logic fs_p = 1'b0, bit_p = 1'b0, xfer_p = 1'b0, slot_p = 1'b0, txfs_p = 1'b0;
  logic [3:0] slots_p = '0;
  logic [3:0] status;

  // bench-side mode settings, applied to the ports by the driver
  logic sync_m = 1'b1, net_m = 1'b1;
  logic [2:0] txen_m = 3'b001;
  logic [1:0] dir_m = 2'b00;
  logic [3:0] slots_m = 4'd3;

  // reference state
  logic [1:0] m_pend = '0, m_lat = '0, m_if = '0;
  logic m_wfs = 1'b0, m_rfs = 1'b0, m_tfs = 1'b0;
  logic [3:0] m_slot = '0;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_status_flags i_tdm_status_flags (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .sync_mode_i(sync_p),
    .net_mode_i(net_p), .tx_en_i(txen_p), .aux_out_i(dir_p), .aux_i(aux_p),
    .rx_fs_i(fs_p), .rx_bit_i(bit_p), .rx_xfer_i(xfer_p), .tx_slot_i(slot_p),
    .tx_fs_i(txfs_p), .slots_i(slots_p), .status_o(status)
  );

  task automatic step(input logic fs, input logic bt, input logic xf,
                      input logic [1:0] aux, input logic sl, input logic tf,
                      input logic c, input string tag);
    logic [1:0] en, pd, lat_n, pend_n, if_n;
    logic [3:0] nxt;
    logic wfs_n, rfs_n, tfs_n;
    item_t it;
    @(negedge clk);
    sync_p = sync_m; net_p = net_m; txen_p = txen_m; dir_p = dir_m; slots_p = slots_m;
    fs_p = fs; bit_p = bt; xfer_p = xf; aux_p = aux; slot_p = sl; txfs_p = tf; clr = c;
    en[0] = sync_m & ~txen_m[1] & ~dir_m[0];
    en[1] = sync_m & ~txen_m[2] & ~dir_m[1];
    for (int k = 0; k < 2; k++) begin
      pd[k]     = m_pend[k] | fs;
      lat_n[k]  = (bt & pd[k]) ? aux[k] : m_lat[k];
      pend_n[k] = (bt & pd[k]) ? 1'b0 : pd[k];
      if_n[k]   = !en[k] ? 1'b0 : (xf ? m_lat[k] : m_if[k]);
    end
    wfs_n = xf ? fs : (m_wfs | fs);
    rfs_n = xf ? m_wfs : m_rfs;
    if (!net_m || tf)            nxt = '0;
    else if (sl)                 nxt = (m_slot == slots_m) ? 4'd0 : m_slot + 4'd1;
    else                         nxt = m_slot;
    tfs_n = (txen_m == 3'b000) ? 1'b0 : ((tf | sl) ? (nxt == 4'd0) : m_tfs);
    if (c) begin
      lat_n = '0; pend_n = '0; if_n = '0; wfs_n = 1'b0; rfs_n = 1'b0; nxt = '0; tfs_n = 1'b0;
    end
    m_lat = lat_n; m_pend = pend_n; m_if = if_n; m_wfs = wfs_n; m_rfs = rfs_n;
    m_slot = nxt; m_tfs = tfs_n;
    it.exp = {m_rfs, m_tfs, m_if[1], m_if[0]};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare one item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (status !== it.exp) begin
        n_bad++;
        $display("FAIL %s: status actual %b expected %b", it.tag, status, it.exp);
      end
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'b00, 0, 0, 0, tag);
  endtask

  task automatic word(input logic fs, input logic [1:0] first, input string tag);
    step(fs, 1, 0, first, 0, 0, 0, tag);
    step(0, 1, 0, ~first, 0, 0, 0, tag);   // later bits must not be sampled
    step(0, 1, 0, ~first, 0, 0, 0, tag);
    step(0, 0, 1, ~first, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_ni = 1'b1;
    idle(2, "R1 reset state");

    // R4/R5/R11 capture with frame sync
    word(1, 2'b01, "R4 R11 capture first bit 01");
    idle(1, "R5 hold");
    word(1, 2'b10, "R4 R11 capture first bit 10");
    word(0, 2'b11, "R11 word without sync");
    // sync one cycle ahead of first bit
    step(1, 0, 0, 2'b00, 0, 0, 0, "R4 sync before bit");
    step(0, 0, 0, 2'b11, 0, 0, 0, "R5 no bit yet");
    step(0, 1, 0, 2'b11, 0, 0, 0, "R5 sampled not shown");
    step(0, 0, 0, 2'b00, 0, 0, 0, "R5 sampled not shown");
    step(0, 0, 1, 2'b00, 0, 0, 0, "R4 R11 transfer");
    // sync in transfer cycle belongs to next word
    step(1, 0, 1, 2'b00, 0, 0, 0, "R11 sync on transfer");
    step(0, 1, 0, 2'b00, 0, 0, 0, "R4 bit after sync");
    step(0, 0, 1, 2'b00, 0, 0, 0, "R11 next word tagged");
    idle(1, "R11 hold");

    // enable conditions
    word(1, 2'b11, "R4 both ones");
    txen_m = 3'b011; idle(2, "R2 tx1 disables flag0");
    txen_m = 3'b001; dir_m = 2'b10; idle(2, "R3 pin1 output disables flag1");
    word(1, 2'b11, "R3 flag1 held off");
    dir_m = 2'b00; word(1, 2'b11, "R2 R3 reenabled");
    txen_m = 3'b101; idle(2, "R3 tx2 disables flag1");
    txen_m = 3'b001; sync_m = 1'b0; idle(2, "R2 R3 async mode");
    sync_m = 1'b1; word(1, 2'b01, "R2 sync mode");

    // network slots: 4 slots then 3 slots
    step(0, 0, 0, 2'b00, 0, 1, 0, "R8 R6 tx frame sync");
    for (int i = 0; i < 9; i++) step(0, 0, 0, 2'b00, 1, 0, 0, "R6 R7 slot walk");
    step(0, 0, 0, 2'b00, 0, 1, 0, "R8 fs midframe");
    slots_m = 4'd2;
    for (int i = 0; i < 7; i++) step(0, 0, 0, 2'b00, 1, 0, 0, "R7 wrap at 3");
    step(0, 0, 0, 2'b00, 0, 1, 0, "R8 fs resets");
    step(0, 0, 0, 2'b00, 1, 0, 0, "R6 slot1");
    txen_m = 3'b000; idle(1, "R9 no transmitter");
    step(0, 0, 0, 2'b00, 0, 1, 0, "R9 fs ignored");
    txen_m = 3'b100;
    step(0, 0, 0, 2'b00, 0, 1, 0, "R6 tx2 only");
    step(0, 0, 0, 2'b00, 1, 0, 0, "R6 slot1 tx2");

    // normal mode
    net_m = 1'b0;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 2'b00, 1, 0, 0, "R10 normal mode");
    txen_m = 3'b001;

    // clear mid-activity
    word(1, 2'b11, "R4 before clear");
    step(0, 0, 0, 2'b00, 1, 0, 1, "R1 clear");
    idle(1, "R1 after clear");
    step(0, 0, 1, 2'b00, 0, 0, 0, "R1 latch cleared");
    idle(2, "R1 done");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule